// File: doc/BRIEF.md
# Stop-Grant Clock Gating Controller

This block decides when an on-chip clock domain and an outgoing clock should be stopped during low-power link states. The host sends Stop Grant messages, and each one carries a 3-bit power-action code. The block keeps the code from the most recent message. When the link-stop input rises, the block freezes that code for the whole stop episode. While link-stop stays high, two gate-request outputs assert if the global enable is on and the frozen code's bit is set in the mask for that output.

The masks are indexed by action code: bit N of a mask stands for code N. The codes mean 0 = C2, 1 = C3, 2 = frequency/voltage change, 3 = S1, 4 = S3, 5 = throttling and 6 = S4/S5. A 32-bit control word, written through a plain write strobe, sets the masks and the enable. Typical values are 0004_0008h, which gates during S1, and 0004_0A0Ah, which gates during C3 and S1.

When the external request is active, the clock gating cells downstream hold the outgoing clock and its grids low. When it is inactive, that clock keeps running through link-stop. The Stop Grant input is a valid strobe with a code. It has no back-pressure: every strobe is taken in the cycle it is presented.

Top module: `cg_stopgrant_gate`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0000_0000h and both gate requests are low.
- R2: A write whose bits 17:16 are both zero loads the control word. The internal mask is bits 7:0, the external mask is bits 15:8 and the enable is bit 18. From the next cycle, `cfg_rd_data` returns the written value ANDed with 0004_FFFFh, so bits 31:19 and 17:16 always read as zero.
- R3: A write with bit 16 or bit 17 set is dropped whole, and the readback keeps its previous value.
- R4: Each `sg_valid` strobe stores `sg_code` as the latched action code. The stored code holds until the next strobe, across any number of stop episodes.
- R5: When `link_stop` rises, the episode code is the latched code as of the cycle before. A Stop Grant that arrives while `link_stop` is high only affects the next episode.
- R6: One cycle after a cycle in which `link_stop` is high, `int_gate_req` equals the enable bit ANDed with the internal-mask bit selected by the episode code. The mask and enable values are those stored during that cycle.
- R7: The same rule as R6 applies to `ext_gate_req`, using the external mask.
- R8: With the enable bit at zero, neither request is high in the following cycle, whatever the masks hold.
- R9: Both requests are low in the cycle after any cycle in which `link_stop` is low.
- R10: If no Stop Grant has been seen since reset, no stop episode produces a gate request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write value |
| cfg_rd_data | output | 32 | Stored control word |
| sg_valid | input | 1 | Stop Grant message strobe |
| sg_code | input | 3 | Power-action code carried by the message |
| link_stop | input | 1 | Link-stop level, high while the link is stopped |
| int_gate_req | output | 1 | Request to gate the internal clock domain |
| ext_gate_req | output | 1 | Request to hold the outgoing clock low |

## Verification
The directed cases use the two typical settings with codes 1, 3 and 5. This tells apart a code that gates both domains, a code that gates only the internal domain, and a code that gates neither. Further directed cases send a Stop Grant in the middle of an episode and check whether it leaks into the running episode or carries into the next one. Others clear the enable with full masks, send writes with each must-be-zero bit set, and start an episode before any Stop Grant has arrived. The random phase mixes writes, strobes and stop episodes of random length, so that mask changes land inside episodes and codes change between them.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned NUM_CODES = 8;
  localparam int unsigned CODE_W    = $clog2(NUM_CODES);
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_DOM   = 2;

  // control word field positions
  localparam int unsigned INT_LSB = 0;
  localparam int unsigned EXT_LSB = 8;
  localparam int unsigned MBZ_LSB = 16;
  localparam int unsigned MBZ_W   = 2;
  localparam int unsigned EN_BIT  = 18;

  localparam logic [WORD_W-1:0] KEEP_MASK = 32'h0004_FFFF;

  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [NUM_CODES-1:0] mask_t;

  typedef struct packed {
    logic  en;
    mask_t ext_mask;
    mask_t int_mask;
  } ctrl_t;
endpackage

// File: rtl/cg_cfg_reg.sv
module cg_cfg_reg
  import cg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q, ctrl_d;
  logic  wr_ok;

  assign wr_ok = wr_en && (wr_data[MBZ_LSB +: MBZ_W] == '0);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) begin
      ctrl_d.int_mask = wr_data[INT_LSB +: NUM_CODES];
      ctrl_d.ext_mask = wr_data[EXT_LSB +: NUM_CODES];
      ctrl_d.en       = wr_data[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[INT_LSB +: NUM_CODES]  = ctrl_q.int_mask;
    rd_data[EXT_LSB +: NUM_CODES]  = ctrl_q.ext_mask;
    rd_data[EN_BIT]                = ctrl_q.en;
  end

  assign ctrl = ctrl_q;

  // R3
  bad_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[MBZ_LSB +: MBZ_W] != '0) |=> $stable(rd_data));

  // R2
  good_write_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[MBZ_LSB +: MBZ_W] == '0) |=> (rd_data == ($past(wr_data) & KEEP_MASK)));
endmodule

// File: rtl/cg_code_latch.sv
module cg_code_latch
  import cg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sg_valid,
  input  code_t sg_code,
  input  logic  link_stop,
  output code_t eff_code,
  output logic  eff_valid
);
  code_t last_q;
  logic  last_vld_q;
  code_t ep_q;
  logic  ep_vld_q;
  logic  stop_q;
  logic  stop_rise;

  assign stop_rise = link_stop && !stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= '0;
      last_vld_q <= 1'b0;
    end else if (sg_valid) begin
      last_q     <= sg_code;
      last_vld_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q   <= 1'b0;
      ep_q     <= '0;
      ep_vld_q <= 1'b0;
    end else begin
      stop_q <= link_stop;
      if (stop_rise) begin
        ep_q     <= last_q;
        ep_vld_q <= last_vld_q;
      end
    end
  end

  // on the first stop cycle the frozen copy is not loaded yet
  assign eff_code  = stop_rise ? last_q     : ep_q;
  assign eff_valid = stop_rise ? last_vld_q : ep_vld_q;

  // R5
  episode_code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_stop && stop_q) |=> ($stable(ep_q) && $stable(ep_vld_q)));

  // R4
  code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sg_valid |=> $stable(last_q));
endmodule

// File: rtl/cg_gate_gen.sv
module cg_gate_gen
  import cg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrl_t                     ctrl,
  input  logic                      link_stop,
  input  code_t                     eff_code,
  input  logic                      eff_valid,
  output logic [NUM_DOM-1:0]        req
);
  mask_t [NUM_DOM-1:0] masks;
  logic                arm;

  assign masks[0] = ctrl.int_mask;
  assign masks[1] = ctrl.ext_mask;
  assign arm      = link_stop && ctrl.en && eff_valid;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic req_q;
    always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= arm && masks[d][eff_code];
    end
    assign req[d] = req_q;
  end

  // R8
  disabled_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (req == '0));

  // R9
  released_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_stop |=> (req == '0));

  // R10
  no_code_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_stop && !eff_valid) |=> (req == '0));
endmodule

// File: rtl/cg_stopgrant_gate.sv
module cg_stopgrant_gate
  import cg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  input  logic        sg_valid,
  input  logic [2:0]  sg_code,
  input  logic        link_stop,
  output logic        int_gate_req,
  output logic        ext_gate_req
);
  ctrl_t               ctrl;
  code_t               eff_code;
  logic                eff_valid;
  logic [NUM_DOM-1:0]  req;

  cg_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .ctrl    (ctrl)
  );

  cg_code_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sg_valid  (sg_valid),
    .sg_code   (sg_code),
    .link_stop (link_stop),
    .eff_code  (eff_code),
    .eff_valid (eff_valid)
  );

  cg_gate_gen u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .link_stop (link_stop),
    .eff_code  (eff_code),
    .eff_valid (eff_valid),
    .req       (req)
  );

  assign int_gate_req = req[0];
  assign ext_gate_req = req[1];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_rd_data == '0 && !int_gate_req && !ext_gate_req));
endmodule

// File: tb/test_cg_stopgrant_gate.sv
module test_cg_stopgrant_gate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        sg_valid;
  logic [2:0]  sg_code;
  logic        link_stop;
  logic        int_gate_req;
  logic        ext_gate_req;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // model state
  logic [31:0] m_reg;
  logic [2:0]  m_code, m_ep;
  logic        m_cv, m_epv, m_ls, m_int, m_ext;

  always #5 clk = ~clk;

  cg_stopgrant_gate i_cg_stopgrant_gate (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .sg_valid(sg_valid), .sg_code(sg_code),
    .link_stop(link_stop), .int_gate_req(int_gate_req), .ext_gate_req(ext_gate_req)
  );

  function automatic logic gate_of(logic [31:0] r, int lsb, logic [2:0] c, logic v, logic ls);
    return ls && r[18] && v && r[lsb + c];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic wr, logic [31:0] wd, logic sv, logic [2:0] sc, logic ls);
    logic [2:0] ep_n;
    logic       epv_n;
    cfg_wr_en = wr; cfg_wr_data = wd; sg_valid = sv; sg_code = sc; link_stop = ls;
    ep_n  = (ls && !m_ls) ? m_code : m_ep;
    epv_n = (ls && !m_ls) ? m_cv   : m_epv;
    m_int = gate_of(m_reg, 0, ep_n, epv_n, ls);
    m_ext = gate_of(m_reg, 8, ep_n, epv_n, ls);
    m_ep = ep_n; m_epv = epv_n; m_ls = ls;
    if (sv) begin m_code = sc; m_cv = 1'b1; end
    if (wr && wd[17:16] == 2'b00) m_reg = wd & 32'h0004_FFFF;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(string tr, string ti, string te);
    chk(tr, cfg_rd_data, m_reg);
    chk(ti, {31'd0, int_gate_req}, {31'd0, m_int});
    chk(te, {31'd0, ext_gate_req}, {31'd0, m_ext});
  endtask

  task automatic idle(logic ls);
    step(1'b0, '0, 1'b0, 3'd0, ls);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    m_reg = '0; m_code = '0; m_ep = '0; m_cv = 0; m_epv = 0; m_ls = 0; m_int = 0; m_ext = 0;
    rst_n = 1'b0; cfg_wr_en = 0; cfg_wr_data = '0; sg_valid = 0; sg_code = '0; link_stop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1", "R1", "R1");

    // R10: episode with enable and full masks but no Stop Grant yet
    step(1'b1, 32'h0004_FFFF, 1'b0, 3'd0, 1'b0);
    idle(1'b1); idle(1'b1);
    chk_all("R2", "R10", "R10");
    idle(1'b0);

    // R3: each must-be-zero bit set drops the write
    step(1'b1, 32'h0005_0000, 1'b0, 3'd0, 1'b0);
    chk("R3", cfg_rd_data, 32'h0004_FFFF);
    step(1'b1, 32'hFFFE_1234, 1'b0, 3'd0, 1'b0);
    chk("R3", cfg_rd_data, 32'h0004_FFFF);
    step(1'b1, 32'hFFF8_0000, 1'b0, 3'd0, 1'b0);
    chk("R2", cfg_rd_data, 32'h0000_0000);

    // R6/R7: gate during S1 only (code 3)
    step(1'b1, 32'h0004_0008, 1'b1, 3'd3, 1'b0);
    idle(1'b1);
    chk("R6", {31'd0, int_gate_req}, 32'd1);
    chk("R7", {31'd0, ext_gate_req}, 32'd0);
    idle(1'b0);
    chk("R9", {31'd0, int_gate_req}, 32'd0);

    // mobile setting, code 1 gates both
    step(1'b1, 32'h0004_0A0A, 1'b1, 3'd1, 1'b0);
    idle(1'b1);
    chk("R7", {31'd0, ext_gate_req}, 32'd1);
    chk("R6", {31'd0, int_gate_req}, 32'd1);
    // R5: Stop Grant mid-episode with code 5 does not change the episode
    step(1'b0, '0, 1'b1, 3'd5, 1'b1);
    idle(1'b1);
    chk("R5", {31'd0, int_gate_req}, 32'd1);
    idle(1'b0);
    // R4: code 5 now latched and kept for the next episode
    idle(1'b1); idle(1'b1);
    chk("R4", {31'd0, int_gate_req}, 32'd0);
    idle(1'b0);

    // R8: enable off with full masks
    step(1'b1, 32'h0000_FFFF, 1'b1, 3'd3, 1'b0);
    idle(1'b1); idle(1'b1);
    chk("R8", {31'd0, int_gate_req}, 32'd0);
    chk("R8", {31'd0, ext_gate_req}, 32'd0);
    idle(1'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic        wr, sv, ls;
      logic [31:0] wd;
      wr = ($urandom % 8) == 0;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[17:16] = 2'b00;
      if (($urandom % 3) != 0) wd[18] = 1'b1;
      sv = ($urandom % 6) == 0;
      ls = (($urandom % 10) == 0) ? ~m_ls : m_ls;
      step(wr, wd, sv, 3'($urandom), ls);
      chk_all("R2", "R6", "R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule